// File: doc/BRIEF.md
# Byte-Wide Data Port with Paired FIFOs

This block is the host-facing register window in front of a security coprocessor. It has four byte registers at consecutive offsets. Offset 0 is the outbound queue, offset 1 is the inbound queue, offset 2 reports the queue and interrupt state, and offset 3 holds the control byte. The host pushes command bytes through offset 0 and pops reply bytes from offset 1. The coprocessor side drains the outbound queue and fills the inbound queue through a plain byte-stream port.

The control byte can do three things. It can clear both queues and all sticky flags in one write. It can stall the device-side stream while the block is in low-power mode. It can mask the interrupt line. Writing 0x41 gives the normal working state: not in reset, not in low power, and with the interrupt line masked. A host can flush the block in two ways. It can read offset 0 until that offset shows the drained code 0xFF. It can also pop offset 1 until the read-data-available flag drops.

Top module: `sec_dport`

## Requirements
- R1: Register access uses `cs`, `wr`, a 2-bit `addr` and `wdata`. A read with `cs`=1 and `wr`=0 loads `rdata` at that clock edge. `rdata` holds its value whenever no read takes place. Offset 0 is the outbound queue, 1 the inbound queue, 2 the status byte and 3 the control byte.
- R2: A write to offset 0 appends `wdata` to the outbound queue. The device sees the bytes in order on `dev_out_data` while `dev_out_avail`=1. Each `dev_out_take` removes the head byte.
- R3: Each queue holds 16 bytes. A host write to a full outbound queue is dropped and clears status bit 2.
- R4: A read of offset 1 pops the inbound queue in arrival order. When that queue is empty, the read returns 0x00, leaves the queue unchanged and clears status bit 2. Bit 2 stays clear until a clear command.
- R5: A read of offset 0 has no side effect. It returns 0xFF when the outbound queue is empty and otherwise returns the number of bytes waiting.
- R6: The status byte reads as follows: bit 0 = outbound queue empty, bit 3 = outbound queue not full, bit 7 = inbound data available, bits 4 and 5 = 0. After reset it reads 0x0D.
- R7: The control register keeps bits 0, 1 and 6 of the value written, and a read of offset 3 returns them. Low power is active when bit 1=1 and bit 0=0. Low power shows as status bit 1 and forces `dev_out_avail`=0 and `dev_in_room`=0.
- R8: Every accepted device byte sets status bit 6. A read of the status byte clears bit 6, and that read still returns the bit as set. `irq` = status bit 6 AND NOT control bit 6.
- R9: A control write with bit 2 set empties both queues, restores status bit 2 and clears status bit 6 at that same clock edge. Writing 0x41 leaves low power off and `irq` low.
- R10: A `dev_in_push` while `dev_in_room`=0 is dropped. The inbound queue contents and status bit 6 stay unchanged.
- R11: Writes to offsets 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register access select |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| dev_out_data | output | 8 | Head byte of the outbound queue |
| dev_out_avail | output | 1 | Outbound byte present and stream not stalled |
| dev_out_take | input | 1 | Device consumes the head byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_push | input | 1 | Device offers a byte |
| dev_in_room | output | 1 | Inbound queue can accept a byte |

## Verification
The hardest states to reach from the ports are the two overflow edges. One is the seventeenth host write into a full outbound queue. The other is a device push arriving when the inbound queue is full. Directed loops fill each queue to 16 entries, offer one more byte, and then drain the queue through the opposite side, so the bench can confirm that the extra byte never appears. The stall case needs the control byte to be in low power while a byte is already waiting. The bench therefore queues a byte first and then enters low power, checks that the stream is frozen, and finally releases low power through the override bit.

// File: rtl/sec_dport_pkg.sv
package sec_dport_pkg;
   typedef enum logic [1:0] {
      OFS_TXQ  = 2'd0,
      OFS_RXQ  = 2'd1,
      OFS_STAT = 2'd2,
      OFS_CTRL = 2'd3
   } dport_ofs_e;

   // control byte bit positions
   localparam int CTL_WAKE  = 0;
   localparam int CTL_LP    = 1;
   localparam int CTL_CLR   = 2;
   localparam int CTL_IMASK = 6;
   localparam logic [7:0] CTL_KEEP = 8'h43;

   // status byte bit positions
   localparam int ST_TXE  = 0;
   localparam int ST_LPA  = 1;
   localparam int ST_FOK  = 2;
   localparam int ST_TOK  = 3;
   localparam int ST_IRQ  = 6;
   localparam int ST_RDA  = 7;
endpackage

// File: rtl/sec_dport_fifo.sv
module sec_dport_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sec_dport_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem[rd_ptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3: occupancy never passes the depth
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R3: a push into a full queue without a pop leaves it unchanged
   a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> $stable(count) && $stable(wr_ptr));
   // R4: a pop of an empty queue moves no pointer
   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> (count == '0) && $stable(rd_ptr));
endmodule

// File: rtl/sec_dport_ctrl.sv
module sec_dport_ctrl
   import sec_dport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       err_evt,
   input  logic       irq_evt,
   input  logic       stat_rd,
   input  logic       txq_empty,
   input  logic       txq_full,
   input  logic       rxq_avail,
   output logic [7:0] ctl_q,
   output logic       soft_clr,
   output logic       lp_active,
   output logic       irq_pend,
   output logic [7:0] stat_byte
);
   logic err_q;

   assign soft_clr  = ctl_we & ctl_wdata[CTL_CLR];
   assign lp_active = ctl_q[CTL_LP] & ~ctl_q[CTL_WAKE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         err_q    <= 1'b0;
         irq_pend <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= ctl_wdata & CTL_KEEP;
         if (soft_clr)     err_q <= 1'b0;
         else if (err_evt) err_q <= 1'b1;
         if (soft_clr)     irq_pend <= 1'b0;
         else if (irq_evt) irq_pend <= 1'b1;
         else if (stat_rd) irq_pend <= 1'b0;
      end
   end

   always_comb begin
      stat_byte         = '0;
      stat_byte[ST_TXE] = txq_empty;
      stat_byte[ST_LPA] = lp_active;
      stat_byte[ST_FOK] = ~err_q;
      stat_byte[ST_TOK] = ~txq_full;
      stat_byte[ST_IRQ] = irq_pend;
      stat_byte[ST_RDA] = rxq_avail;
   end

   // R4: the error flag is sticky until a clear command
   a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !soft_clr) |=> err_q);
   // R9: a clear command drops both sticky flags
   a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (!err_q && !irq_pend));
endmodule

// File: rtl/sec_dport.sv
module sec_dport
   import sec_dport_pkg::*;
#(
   parameter int         DEPTH      = 16,
   parameter logic [7:0] DRAIN_CODE = 8'hFF,
   parameter logic [7:0] EMPTY_CODE = 8'h00,
   localparam int        CW         = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs,
   input  logic       wr,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq,
   output logic [7:0] dev_out_data,
   output logic       dev_out_avail,
   input  logic       dev_out_take,
   input  logic [7:0] dev_in_data,
   input  logic       dev_in_push,
   output logic       dev_in_room
);
   generate
      if (CW > 8) begin : g_bad_count
         $error("sec_dport: DEPTH too large for a byte-wide fill count");
      end
   endgenerate

   logic          wr_evt, rd_evt;
   logic          txq_push, txq_pop, rxq_push, rxq_pop;
   logic          txq_empty, txq_full, rxq_empty, rxq_full;
   logic [7:0]    txq_head, rxq_head;
   logic [CW-1:0] txq_cnt, rxq_cnt;
   logic [7:0]    ctl_q, stat_byte;
   logic          soft_clr, lp_active, irq_pend;
   logic          err_evt, irq_evt, stat_rd;
   logic [7:0]    rd_mux;

   assign wr_evt   = cs & wr;
   assign rd_evt   = cs & ~wr;
   assign txq_push = wr_evt & (addr == OFS_TXQ);
   assign rxq_pop  = rd_evt & (addr == OFS_RXQ);
   assign stat_rd  = rd_evt & (addr == OFS_STAT);

   assign dev_out_avail = ~txq_empty & ~lp_active;
   assign dev_in_room   = ~rxq_full & ~lp_active;
   assign dev_out_data  = txq_head;
   assign txq_pop       = dev_out_take & dev_out_avail;
   assign rxq_push      = dev_in_push & dev_in_room;

   assign err_evt = (txq_push & txq_full) | (rxq_pop & rxq_empty);
   assign irq_evt = rxq_push;
   assign irq     = irq_pend & ~ctl_q[CTL_IMASK];

   sec_dport_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push(txq_push), .din(wdata), .pop(txq_pop),
      .head(txq_head), .empty(txq_empty), .full(txq_full), .count(txq_cnt)
   );

   sec_dport_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push(rxq_push), .din(dev_in_data), .pop(rxq_pop),
      .head(rxq_head), .empty(rxq_empty), .full(rxq_full), .count(rxq_cnt)
   );

   sec_dport_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(wr_evt & (addr == OFS_CTRL)), .ctl_wdata(wdata),
      .err_evt(err_evt), .irq_evt(irq_evt), .stat_rd(stat_rd),
      .txq_empty(txq_empty), .txq_full(txq_full), .rxq_avail(~rxq_empty),
      .ctl_q(ctl_q), .soft_clr(soft_clr), .lp_active(lp_active),
      .irq_pend(irq_pend), .stat_byte(stat_byte)
   );

   always_comb begin
      case (addr)
         OFS_TXQ:  rd_mux = txq_empty ? DRAIN_CODE : 8'(txq_cnt);
         OFS_RXQ:  rd_mux = rxq_empty ? EMPTY_CODE : rxq_head;
         OFS_STAT: rd_mux = stat_byte;
         default:  rd_mux = ctl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_evt) rdata <= rd_mux;
   end

   // R1: read data moves only on a read access
   a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_evt |=> $stable(rdata));
   // R7: low power freezes the device stream
   a_r7_lp_stall: assert property (@(posedge clk) disable iff (!rst_n)
      lp_active |-> (!dev_out_avail && !dev_in_room));
   // R8: a masked interrupt never reaches the pin
   a_r8_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CTL_IMASK] |-> !irq);
   // R9: the clear command empties both queues at its edge
   a_r9_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (txq_cnt == '0 && rxq_cnt == '0));
endmodule

// File: tb/sec_dport_bench.sv
`timescale 1ns/1ps
module sec_dport_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, wr = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   logic [7:0] dev_out_data;
   logic       dev_out_avail;
   logic       dev_out_take = 1'b0;
   logic [7:0] dev_in_data = '0;
   logic       dev_in_push = 1'b0;
   logic       dev_in_room;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sec_dport u_sec_dport (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .dev_out_data(dev_out_data),
      .dev_out_avail(dev_out_avail), .dev_out_take(dev_out_take),
      .dev_in_data(dev_in_data), .dev_in_push(dev_in_push),
      .dev_in_room(dev_in_room)
   );

   // vector: [23] wr, [22:21] addr, [20:13] wdata, [12:5] expected, [4] check, [3:0] req
   localparam int NV = 16;
   localparam logic [23:0] VEC [0:NV-1] = '{
      {1'b0, 2'd2, 8'h00, 8'h0D, 1'b1, 4'd6},  // R6 reset status
      {1'b0, 2'd0, 8'h00, 8'hFF, 1'b1, 4'd5},  // R5 drained code
      {1'b0, 2'd3, 8'h00, 8'h00, 1'b1, 4'd7},  // R7 control reset value
      {1'b1, 2'd0, 8'hA5, 8'h00, 1'b0, 4'd2},
      {1'b1, 2'd0, 8'h3C, 8'h00, 1'b0, 4'd2},
      {1'b0, 2'd0, 8'h00, 8'h02, 1'b1, 4'd5},  // R5 fill count
      {1'b0, 2'd2, 8'h00, 8'h0C, 1'b1, 4'd6},  // R6 not empty
      {1'b0, 2'd1, 8'h00, 8'h00, 1'b1, 4'd4},  // R4 empty pop code
      {1'b0, 2'd2, 8'h00, 8'h08, 1'b1, 4'd4},  // R4 fifo-ok cleared
      {1'b1, 2'd3, 8'h41, 8'h00, 1'b0, 4'd9},
      {1'b0, 2'd3, 8'h00, 8'h41, 1'b1, 4'd7},  // R7 stored bits
      {1'b1, 2'd1, 8'h77, 8'h00, 1'b0, 4'd11},
      {1'b1, 2'd2, 8'h55, 8'h00, 1'b0, 4'd11},
      {1'b0, 2'd2, 8'h00, 8'h08, 1'b1, 4'd11}, // R11 no effect
      {1'b1, 2'd3, 8'h04, 8'h00, 1'b0, 4'd9},
      {1'b0, 2'd2, 8'h00, 8'h0D, 1'b1, 4'd9}   // R9 cleared
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      cs = 1'b0;
      d = rdata;
   endtask

   task automatic dev_push(input logic [7:0] d);
      @(negedge clk);
      dev_in_push = 1'b1; dev_in_data = d;
      @(negedge clk);
      dev_in_push = 1'b0;
   endtask

   task automatic dev_take(input string tag, input logic [7:0] exp);
      @(negedge clk);
      chk(tag, {7'd0, dev_out_avail}, 8'h01);
      chk(tag, dev_out_data, exp);
      dev_out_take = 1'b1;
      @(negedge clk);
      dev_out_take = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state of outputs
      chk("R1 rdata reset", rdata, 8'h00);
      chk("R8 irq reset", {7'd0, irq}, 8'h00);
      chk("R2 no outbound byte", {7'd0, dev_out_avail}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][23]) bus_wr(VEC[i][22:21], VEC[i][20:13]);
         else begin
            bus_rd(VEC[i][22:21], r);
            if (VEC[i][4]) chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, VEC[i][12:5]);
         end
      end

      // R2: order on the device side
      bus_wr(2'd0, 8'h10); bus_wr(2'd0, 8'h20); bus_wr(2'd0, 8'h30);
      dev_take("R2 first", 8'h10);
      dev_take("R2 second", 8'h20);
      dev_take("R2 third", 8'h30);
      @(negedge clk);
      chk("R2 drained", {7'd0, dev_out_avail}, 8'h00);

      // R3: seventeenth write dropped
      for (int k = 0; k < 17; k++) bus_wr(2'd0, 8'(8'h40 + k));
      bus_rd(2'd0, r); chk("R3 fill count", r, 8'h10);
      bus_rd(2'd2, r); chk("R3 full status", r, 8'h00);
      for (int k = 0; k < 16; k++) dev_take("R3 drain", 8'(8'h40 + k));
      @(negedge clk);
      chk("R3 extra byte absent", {7'd0, dev_out_avail}, 8'h00);
      bus_wr(2'd3, 8'h04);

      // R8: interrupt set by device bytes, cleared by status read
      dev_push(8'h11); dev_push(8'h22);
      chk("R8 irq raised", {7'd0, irq}, 8'h01);
      bus_rd(2'd2, r); chk("R8 status with irq", r, 8'hCD);
      chk("R8 irq cleared", {7'd0, irq}, 8'h00);
      bus_rd(2'd2, r); chk("R8 status after read", r, 8'h8D);
      bus_rd(2'd1, r); chk("R4 pop first", r, 8'h11);
      bus_rd(2'd1, r); chk("R4 pop second", r, 8'h22);
      bus_rd(2'd2, r); chk("R4 flushed", r, 8'h0D);

      // R10: inbound overflow dropped
      for (int k = 0; k < 16; k++) dev_push(8'(8'h80 + k));
      chk("R10 no room", {7'd0, dev_in_room}, 8'h00);
      bus_rd(2'd2, r);
      dev_push(8'hEE);
      bus_rd(2'd2, r); chk("R10 irq untouched by dropped push", r, 8'h8D);
      for (int k = 0; k < 16; k++) begin
         bus_rd(2'd1, r); chk("R10 drain order", r, 8'(8'h80 + k));
      end
      bus_rd(2'd2, r); chk("R10 extra byte absent", r, 8'h0D);

      // R7: low power stalls the stream
      bus_wr(2'd0, 8'h5A);
      bus_wr(2'd3, 8'h02);
      bus_rd(2'd2, r); chk("R7 low power status", r, 8'h0E);
      chk("R7 out stalled", {7'd0, dev_out_avail}, 8'h00);
      chk("R7 in stalled", {7'd0, dev_in_room}, 8'h00);
      dev_push(8'h66);
      bus_wr(2'd3, 8'h43);
      bus_rd(2'd3, r); chk("R7 wake override", r, 8'h43);
      bus_rd(2'd2, r); chk("R7 push in low power dropped", r, 8'h0C);
      dev_take("R7 byte after wake", 8'h5A);

      // R9: 0x41 masks the interrupt
      bus_wr(2'd3, 8'h41);
      dev_push(8'h99);
      chk("R9 irq masked", {7'd0, irq}, 8'h00);
      bus_wr(2'd0, 8'h12);
      bus_rd(2'd2, r); chk("R9 pending still visible", r, 8'hCC);
      dev_push(8'h98);
      // R9: clear with data in both queues
      bus_wr(2'd3, 8'h44);
      bus_rd(2'd2, r); chk("R9 clear status", r, 8'h0D);
      bus_rd(2'd3, r); chk("R9 control after clear", r, 8'h40);
      bus_rd(2'd0, r); chk("R9 outbound empty", r, 8'hFF);
      bus_rd(2'd1, r); chk("R9 inbound empty", r, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule